// File: doc/BRIEF.md
# Serial Audio Bit and Word Clock Generator

This block derives the two framing clocks of a serial stereo audio link from one master clock that runs at twice the bit-clock rate. The bit clock is a register that inverts on every enabled master edge, so it has a 50% duty cycle at half the master frequency. The word-select clock is a second register. It changes only on the master edge where the bit clock goes from high to low. Both outputs come straight from flip-flops on the same master edge, so the falling edge of the bit clock and every word-select transition line up, with no counter or compare delay between them.

A parameter sets how many bit-clock periods make one word-select period. The value must be even and at least 4, and elaboration stops on any other value. A counter of bit-clock falling edges decides where word-select toggles. A one-cycle frame strobe marks each word-select transition from high to low. The enable input freezes the whole block: while it is low, no output or counter changes. The synchronous reset returns the block to a known phase.

Top module: `audio_clk_gen`

## Requirements
- R1: While reset is sampled high, the bit clock is driven to 1, word-select to 0 and the frame strobe to 0 on the next master edge.
- R2: On every master edge with enable high and reset low, the bit clock inverts. This gives a 50% duty cycle at half the master rate.
- R3: Word-select changes only on a master edge where the bit clock goes from 1 to 0.
- R4: Word-select toggles on every (RATIO/2)-th bit-clock falling edge. The first falling edge after reset toggles it from 0 to 1.
- R5: Each word-select half-period lasts exactly RATIO/2 bit-clock periods. The full word-select period is therefore RATIO bit-clock periods.
- R6: The frame strobe is high for exactly one master cycle. That cycle follows the edge on which word-select went from 1 to 0, and the strobe is low at all other times.
- R7: While enable is low, the bit clock, word-select and the internal fall counter hold, and the strobe is 0. When enable returns high, the sequence continues with no skipped or extra edge.
- R8: A reset applied in the middle of operation restarts the sequence from the R1 state. The phase after reset is the same as after power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, twice the bit-clock rate |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Run enable; low freezes all state |
| bit_clk_o | output | 1 | Registered bit clock |
| word_sel_o | output | 1 | Registered word-select clock |
| frame_start_o | output | 1 | One-cycle strobe after word-select falls |

## Verification
The bench builds the block with RATIO = 6. With that value the half-period of three bit clocks is odd, so the counter's mid-point compare sits at a value that is not a power of two, and the wrap from 5 to 0 exercises a counter range that does not fill its width. The short frame gives many word-select periods within the run. Enable is switched on and off in irregular patterns, and that shows whether a hold on a high or a low bit-clock phase loses or adds an edge.

// File: rtl/audclk_pkg.sv
package audclk_pkg;
  function automatic int cnt_width(input int ratio);
    return (ratio > 2) ? $clog2(ratio) : 1;
  endfunction

  function automatic bit ratio_ok(input int ratio);
    return (ratio >= 4) && ((ratio % 2) == 0);
  endfunction
endpackage

// File: rtl/bitclk_toggle.sv
module bitclk_toggle (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  output logic bclk_o,
  output logic fall_o
);
  logic bclk_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)     bclk_q <= 1'b1;
    else if (en_i) bclk_q <= ~bclk_q;
  end

  // this edge takes the bit clock from high to low
  assign fall_o = en_i & bclk_q;
  assign bclk_o = bclk_q;

  // R2: inverts on each enabled edge
  a_r2_bit_toggle: assert property (@(posedge clk_i) disable iff (rst_i)
    en_i |=> (bclk_q != $past(bclk_q)));
  // R7: holds while disabled
  a_r7_bit_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> $stable(bclk_q));
endmodule

// File: rtl/bitper_counter.sv
module bitper_counter #(
  parameter int RATIO = 8
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic fall_i,
  output logic [audclk_pkg::cnt_width(RATIO)-1:0] cnt_o
);
  localparam int CW = audclk_pkg::cnt_width(RATIO);
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) cnt_q <= '0;
    else if (fall_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R5: the count never leaves 0..RATIO-1
  a_r5_cnt_range: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_q <= LAST);
  // R7: frozen on non-falling edges
  a_r7_cnt_frozen: assert property (@(posedge clk_i) disable iff (rst_i)
    !fall_i |=> $stable(cnt_q));
endmodule

// File: rtl/wordsel_reg.sv
module wordsel_reg #(
  parameter int RATIO = 8
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic fall_i,
  input  logic bclk_i,
  input  logic [audclk_pkg::cnt_width(RATIO)-1:0] cnt_i,
  output logic ws_o,
  output logic fs_o
);
  localparam int CW = audclk_pkg::cnt_width(RATIO);
  localparam logic [CW-1:0] MID = CW'(RATIO / 2);

  logic ws_q, fs_q, at_start, at_mid;

  assign at_start = (cnt_i == '0);
  assign at_mid   = (cnt_i == MID);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ws_q <= 1'b0;
      fs_q <= 1'b0;
    end else begin
      if (fall_i && (at_start || at_mid)) ws_q <= ~ws_q;
      fs_q <= fall_i & at_mid;
    end
  end

  assign ws_o = ws_q;
  assign fs_o = fs_q;

  // R3: word-select moves only together with a bit-clock fall
  a_r3_ws_on_fall: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(ws_q) |-> $fell(bclk_i));
  // R6: strobe follows a word-select fall and lasts one cycle
  a_r6_fs_on_ws_fall: assert property (@(posedge clk_i) disable iff (rst_i)
    fs_q |-> $fell(ws_q));
  a_r6_fs_single: assert property (@(posedge clk_i) disable iff (rst_i)
    fs_q |=> !fs_q);
endmodule

// File: rtl/audio_clk_gen.sv
module audio_clk_gen #(
  parameter int RATIO = 8
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  output logic bit_clk_o,
  output logic word_sel_o,
  output logic frame_start_o
);
  localparam int CW = audclk_pkg::cnt_width(RATIO);

  generate
    if (!audclk_pkg::ratio_ok(RATIO)) begin : g_bad_ratio
      $error("audio_clk_gen: RATIO must be even and at least 4");
    end
  endgenerate

  logic          bclk, fall;
  logic [CW-1:0] cnt;

  bitclk_toggle u_bclk (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .en_i   (en_i),
    .bclk_o (bclk),
    .fall_o (fall)
  );

  bitper_counter #(.RATIO(RATIO)) u_cnt (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .fall_i (fall),
    .cnt_o  (cnt)
  );

  wordsel_reg #(.RATIO(RATIO)) u_ws (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .fall_i (fall),
    .bclk_i (bclk),
    .cnt_i  (cnt),
    .ws_o   (word_sel_o),
    .fs_o   (frame_start_o)
  );

  assign bit_clk_o = bclk;

  // R1, R8: reset state one edge after reset is sampled
  a_r1_reset_state: assert property (@(posedge clk_i)
    rst_i |=> (bit_clk_o && !word_sel_o && !frame_start_o));
endmodule

// File: tb/audio_clk_gen_tb_top.sv
`timescale 1ns/1ps
module audio_clk_gen_tb_top;
  localparam int RATIO = 6;
  localparam int HALF  = RATIO / 2;

  logic clk_i = 1'b0;
  logic rst_i = 1'b1;
  logic en_i  = 1'b0;
  logic bit_clk_o, word_sel_o, frame_start_o;

  always #2.5 clk_i = ~clk_i;

  audio_clk_gen #(.RATIO(RATIO)) dut_i (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .en_i          (en_i),
    .bit_clk_o     (bit_clk_o),
    .word_sel_o    (word_sel_o),
    .frame_start_o (frame_start_o)
  );

  int checks = 0;
  int errors = 0;

  // expected entry: {kind[1:0], bclk, ws, fs}; kind 0 reset, 1 run, 2 hold
  logic [4:0] sb_q[$];

  // reference state, built from the requirements
  logic m_b = 1'b1, m_w = 1'b0, m_f = 1'b0;
  int   m_n = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic e, input logic r);
    logic [1:0] kind;
    @(negedge clk_i);
    en_i  = e;
    rst_i = r;
    if (r) begin
      m_b = 1'b1; m_w = 1'b0; m_f = 1'b0; m_n = 0; kind = 2'd0;
    end else if (e) begin
      kind = 2'd1;
      if (m_b) begin
        m_f = (m_n == HALF);
        if (m_n == 0 || m_n == HALF) m_w = ~m_w;
        m_n = (m_n + 1) % RATIO;
      end else begin
        m_f = 1'b0;
      end
      m_b = ~m_b;
    end else begin
      kind = 2'd2;
      m_f  = 1'b0;
    end
    @(posedge clk_i);
    #1;
    sb_q.push_back({kind, m_b, m_w, m_f});
  endtask

  // monitor: pops expectations and checks edge relations
  logic p_b = 1'b1, p_w = 1'b0;
  int   falls = 0;
  bit   have_edge = 0;

  always @(negedge clk_i) begin
    if (sb_q.size() > 0) begin
      logic [4:0] x;
      string rb, rw, rf;
      x = sb_q.pop_front();
      rb = (x[4:3] == 2'd0) ? "R1" : (x[4:3] == 2'd2) ? "R7" : "R2";
      rw = (x[4:3] == 2'd0) ? "R1" : (x[4:3] == 2'd2) ? "R7" : "R4";
      rf = (x[4:3] == 2'd0) ? "R1" : "R6";
      check(bit_clk_o === x[2], rb, "bit clock", int'(bit_clk_o), int'(x[2]));
      check(word_sel_o === x[1], rw, "word select", int'(word_sel_o), int'(x[1]));
      check(frame_start_o === x[0], rf, "frame strobe", int'(frame_start_o), int'(x[0]));
      if (x[4:3] == 2'd0) begin
        falls = 0;
        have_edge = 0;
      end else begin
        if (p_b && !bit_clk_o) falls++;
        if (word_sel_o !== p_w) begin
          check(p_b && !bit_clk_o, "R3", "ws change without bit fall",
                int'(bit_clk_o), 0);
          if (have_edge)
            check(falls == HALF, "R5", "bit periods per ws half", falls, HALF);
          have_edge = 1;
          falls = 0;
        end
      end
      p_b = bit_clk_o;
      p_w = word_sel_o;
    end
  end

  initial begin
    #(5.0 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] lfsr;
    lfsr = 8'hA5;
    // R1: reset state
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1);
    // R2, R4, R5, R6: free run
    for (int i = 0; i < 60; i++) step(1'b1, 1'b0);
    // R7: hold on both bit-clock phases
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
    // R7: irregular enable pattern
    for (int i = 0; i < 120; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[0] | lfsr[2], 1'b0);
    end
    // R8: reset in the middle of a frame
    for (int i = 0; i < 7; i++) step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    for (int i = 0; i < 50; i++) step(1'b1, 1'b0);
    @(negedge clk_i);
    @(negedge clk_i);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule